// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block picks which interrupt a CPU core serves next when several requests compete and interrupts may nest. It has up to fourteen maskable sources and one non-maskable source. Each maskable source has a two-bit software level that software writes into a per-source level register. Each source also has a fixed hardware rank given by its vector address. The current level of the running code arrives as a two-bit pair from the condition-code register. The pair uses a non-numeric encoding that keeps the all-ones value meaning "interrupts disabled".

At an instruction boundary the controller compares every pending request against the current level. A maskable request qualifies only when its software level is strictly above the current one. The winner is the qualifying request with the highest software level, and among equal levels the one at the higher vector address. The controller then reports the vector address and the level pair the CPU must load into its condition codes, and saves the interrupted level on a small internal stack. It stays busy for a fixed context-switch time. A return strobe restores the most recently saved level. The non-maskable source ignores all levels.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `intTaken`, `ccLoad` and `busy` are 0, `vecAddr` is FFFEh, and every source's level register holds pair 11.
- R2: Level pairs rank as 10→0, 01→1, 00→2, 11→3. A maskable request qualifies only if its rank is strictly greater than the rank of `curLevel`, so a current pair of 11 blocks every maskable source.
- R3: Among qualifying maskable requests, the one with the highest rank wins, and a tie goes to the higher source index. Source i uses vector FFE0h + 2·i.
- R4: A take made at a clock edge shows, in the cycle after that edge, a one-cycle `intTaken` pulse together with a one-cycle `ccLoad` pulse. In that cycle `vecAddr` carries the winner's vector and `ccLevel` carries its level pair. `vecAddr` holds its value until the next take.
- R5: A take is decided only at an edge where `instrEnd` is 1.
- R6: After a take, `busy` is 1 for exactly 10 cycles and no take is decided while it is 1. A request still present is taken at the first boundary edge after that.
- R7: A rising edge on `nmiReq` is latched until it is served. It wins over every maskable request at any `curLevel` (including 11), uses vector FFFCh and loads pair 11. A level held high is served only once.
- R8: Each take pushes the `curLevel` present at that edge. A `retStrobe` with a non-empty stack pops the newest entry and shows it on `ccLevel` with a one-cycle `ccLoad` in the next cycle. A `retStrobe` with an empty stack changes nothing. Any `retStrobe` suppresses a take at the same edge.
- R9: A write with `cfgWrEn` stores `cfgWrLevel` into source `cfgWrIdx` at that edge. The new level is used for decisions from the following edge on.
- R10: The level stack holds 8 entries. A push onto a full stack discards the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | NUM_SRC | Maskable request lines, index = hardware rank |
| nmiReq | input | 1 | Non-maskable request, rising edge latched |
| curLevel | input | 2 | Current level pair from the condition codes |
| cfgWrEn | input | 1 | Level register write enable |
| cfgWrIdx | input | IDX_W | Source index to write |
| cfgWrLevel | input | 2 | Level pair to write |
| instrEnd | input | 1 | Instruction boundary strobe |
| retStrobe | input | 1 | Return-from-interrupt strobe |
| intTaken | output | 1 | One-cycle pulse when an interrupt is taken |
| vecAddr | output | 16 | Vector address of the last take |
| ccLevel | output | 2 | Level pair the CPU loads into its condition codes |
| ccLoad | output | 1 | One-cycle pulse qualifying `ccLevel` |
| busy | output | 1 | Context switch in progress |

## Verification
Every result is registered once, so a take or return decided at one edge appears in the cycle after it. The busy window then closes exactly ten cycles later. The bench carries a behavioural model that updates at the same rising edge as the design, from the input values driven at the preceding falling edge. It compares all five outputs at every falling edge, where both are stable. Sequences probe level ties, strict-greater rejection, boundary gating, back-to-back takes across the busy window, NMI latching, return/take collisions and stack overflow.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic take;   // take an interrupt at this edge
    logic nmi;    // the take serves the non-maskable source
    logic ret;    // pop the saved level
  } ctlStrobe_t;

  // numeric rank of a level pair
  function automatic logic [1:0] levelRank(input logic [1:0] pair);
    case (pair)
      2'b10:   return 2'd0;
      2'b01:   return 2'd1;
      2'b00:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/nest_irq_ctrl_fsm.sv
module nest_irq_ctrl_fsm
  import nest_irq_pkg::*;
#(
  parameter int SWITCH_CYCLES = 10,
  localparam int CNT_W = $clog2(SWITCH_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrEnd,
  input  logic       retStrobe,
  input  logic       nmiReq,
  input  logic       maskAvail,
  input  logic       stackNonEmpty,
  output ctlStrobe_t strb,
  output logic       busy
);

  logic [CNT_W-1:0] busyCnt;
  logic             nmiPrev;
  logic             nmiPend;
  logic             nmiHit;
  logic             canDecide;

  assign nmiHit    = nmiPend | (nmiReq & ~nmiPrev);
  assign canDecide = instrEnd & (busyCnt == '0) & ~retStrobe;

  always_comb begin
    strb.ret  = retStrobe & stackNonEmpty;
    strb.take = canDecide & (nmiHit | maskAvail);
    strb.nmi  = canDecide & nmiHit;
  end

  assign busy = (busyCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiReq;
      nmiPend <= nmiHit & ~strb.nmi;
      if (strb.take)
        busyCnt <= CNT_W'(SWITCH_CYCLES);
      else if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
    end
  end

endmodule

// File: rtl/nest_irq_datapath.sv
module nest_irq_datapath
  import nest_irq_pkg::*;
#(
  parameter int          NUM_SRC     = 14,
  parameter int          STACK_DEPTH = 8,
  parameter logic [15:0] VEC_BASE    = 16'hFFE0,
  parameter logic [15:0] NMI_VEC     = 16'hFFFC,
  parameter logic [15:0] RESET_VEC   = 16'hFFFE,
  localparam int IDX_W = $clog2(NUM_SRC),
  localparam int PTR_W = $clog2(STACK_DEPTH),
  localparam int SCNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [1:0]         curLevel,
  input  logic               cfgWrEn,
  input  logic [IDX_W-1:0]   cfgWrIdx,
  input  logic [1:0]         cfgWrLevel,
  input  ctlStrobe_t         strb,
  input  logic               busy,
  input  logic               instrEnd,
  output logic               maskAvail,
  output logic               stackNonEmpty,
  output logic               intTaken,
  output logic [15:0]        vecAddr,
  output logic [1:0]         ccLevel,
  output logic               ccLoad
);

  logic [1:0]        lvlReg [NUM_SRC];
  logic [1:0]        stackMem [STACK_DEPTH];
  logic [PTR_W-1:0]  stackPtr;
  logic [SCNT_W-1:0] stackCnt;
  logic [IDX_W-1:0]  winIdx;
  logic [1:0]        winRank;
  logic [PTR_W-1:0]  topPtr;

  // per-source level registers
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lvlReg[g] <= 2'b11;
      else if (cfgWrEn && cfgWrIdx == IDX_W'(g))
        lvlReg[g] <= cfgWrLevel;
    end
  end

  // arbitration: highest rank, then highest index
  always_comb begin
    maskAvail = 1'b0;
    winIdx    = '0;
    winRank   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (irqReq[i] && levelRank(lvlReg[i]) > levelRank(curLevel)) begin
        if (!maskAvail || levelRank(lvlReg[i]) >= winRank) begin
          maskAvail = 1'b1;
          winRank   = levelRank(lvlReg[i]);
          winIdx    = IDX_W'(i);
        end
      end
    end
  end

  assign stackNonEmpty = (stackCnt != '0);
  assign topPtr        = stackPtr - 1'b1;

  // saved-level stack, circular, oldest overwritten
  always_ff @(posedge clk) begin
    if (strb.take)
      stackMem[stackPtr] <= curLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackPtr <= '0;
      stackCnt <= '0;
    end else if (strb.ret) begin
      stackPtr <= topPtr;
      stackCnt <= stackCnt - 1'b1;
    end else if (strb.take) begin
      stackPtr <= stackPtr + 1'b1;
      if (stackCnt != SCNT_W'(STACK_DEPTH))
        stackCnt <= stackCnt + 1'b1;
    end
  end

  // registered results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intTaken <= 1'b0;
      ccLoad   <= 1'b0;
      vecAddr  <= RESET_VEC;
      ccLevel  <= 2'b11;
    end else begin
      intTaken <= strb.take;
      ccLoad   <= strb.take | strb.ret;
      if (strb.ret) begin
        ccLevel <= stackMem[topPtr];
      end else if (strb.take) begin
        if (strb.nmi) begin
          vecAddr <= NMI_VEC;
          ccLevel <= 2'b11;
        end else begin
          vecAddr <= VEC_BASE + 16'({winIdx, 1'b0});
          ccLevel <= lvlReg[winIdx];
        end
      end
    end
  end

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    intTaken |=> !intTaken); // R4
  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    intTaken |-> busy); // R6
  AST_TAKE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    intTaken |-> $past(instrEnd)); // R5
  AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && !strb.nmi) |-> levelRank(curLevel) != 2'd3); // R2
  AST_NMI_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (intTaken && vecAddr == NMI_VEC) |-> ccLevel == 2'b11); // R7
  AST_RET_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strb.ret |-> stackCnt != '0); // R8

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int NUM_SRC       = 14,
  parameter int SWITCH_CYCLES = 10,
  parameter int STACK_DEPTH   = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               nmiReq,
  input  logic [1:0]         curLevel,
  input  logic               cfgWrEn,
  input  logic [IDX_W-1:0]   cfgWrIdx,
  input  logic [1:0]         cfgWrLevel,
  input  logic               instrEnd,
  input  logic               retStrobe,
  output logic               intTaken,
  output logic [15:0]        vecAddr,
  output logic [1:0]         ccLevel,
  output logic               ccLoad,
  output logic               busy
);

  ctlStrobe_t strb;
  logic       maskAvail;
  logic       stackNonEmpty;

  nest_irq_ctrl_fsm #(
    .SWITCH_CYCLES(SWITCH_CYCLES)
  ) i_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .instrEnd     (instrEnd),
    .retStrobe    (retStrobe),
    .nmiReq       (nmiReq),
    .maskAvail    (maskAvail),
    .stackNonEmpty(stackNonEmpty),
    .strb         (strb),
    .busy         (busy)
  );

  nest_irq_datapath #(
    .NUM_SRC    (NUM_SRC),
    .STACK_DEPTH(STACK_DEPTH)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .irqReq       (irqReq),
    .curLevel     (curLevel),
    .cfgWrEn      (cfgWrEn),
    .cfgWrIdx     (cfgWrIdx),
    .cfgWrLevel   (cfgWrLevel),
    .strb         (strb),
    .busy         (busy),
    .instrEnd     (instrEnd),
    .maskAvail    (maskAvail),
    .stackNonEmpty(stackNonEmpty),
    .intTaken     (intTaken),
    .vecAddr      (vecAddr),
    .ccLevel      (ccLevel),
    .ccLoad       (ccLoad)
  );

endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;

  localparam int NSRC = 14;
  localparam int DEPTH = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] irqReq = '0;
  logic            nmiReq = 1'b0;
  logic [1:0]      curLevel = 2'b10;
  logic            cfgWrEn = 1'b0;
  logic [3:0]      cfgWrIdx = '0;
  logic [1:0]      cfgWrLevel = '0;
  logic            instrEnd = 1'b0;
  logic            retStrobe = 1'b0;
  logic            intTaken;
  logic [15:0]     vecAddr;
  logic [1:0]      ccLevel;
  logic            ccLoad;
  logic            busy;

  always #4 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .nmiReq(nmiReq),
    .curLevel(curLevel), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrLevel(cfgWrLevel), .instrEnd(instrEnd), .retStrobe(retStrobe),
    .intTaken(intTaken), .vecAddr(vecAddr), .ccLevel(ccLevel),
    .ccLoad(ccLoad), .busy(busy)
  );

  // reference model state
  int         mPrio [NSRC];
  int         mBusy;
  bit         mNmiPrev, mNmiPend;
  int         mStack [$];
  bit         eTaken, eLoad, eBusy;
  logic [15:0] eVec;
  logic [1:0] eLevel;
  bit         modelOn = 0;
  string      phase = "R1";
  int         nChecks = 0, nFails = 0;

  function automatic int rankOf(input logic [1:0] p);
    if (p == 2'b10) return 0;
    if (p == 2'b01) return 1;
    if (p == 2'b00) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mPrio[k]) mPrio[k] = 3;
      mBusy = 0; mNmiPrev = 0; mNmiPend = 0;
      mStack.delete();
      eTaken = 0; eLoad = 0; eBusy = 0; eVec = 16'hFFFE; eLevel = 2'b11;
      modelOn = 1;
    end else begin
      bit nmiHit, doRet, can, doTake, doNmi;
      int best, bestR;
      nmiHit = mNmiPend || (nmiReq && !mNmiPrev);
      doRet  = retStrobe && mStack.size() > 0;
      can    = instrEnd && mBusy == 0 && !retStrobe;
      best = -1; bestR = -1;
      for (int i = 0; i < NSRC; i++) begin
        int r;
        r = mPrio[i];
        if (irqReq[i] && r > rankOf(curLevel) && r >= bestR) begin
          best = i; bestR = r;
        end
      end
      doTake = can && (nmiHit || best >= 0);
      doNmi  = can && nmiHit;
      eTaken = doTake;
      eLoad  = doTake || doRet;
      if (doRet) begin
        eLevel = 2'(mStack[$]);
        void'(mStack.pop_back());
      end else if (doTake) begin
        mStack.push_back(int'(curLevel));
        if (mStack.size() > DEPTH) void'(mStack.pop_front());
        if (doNmi) begin
          eVec = 16'hFFFC; eLevel = 2'b11;
        end else begin
          eVec = 16'hFFE0 + 16'(2 * best);
          case (mPrio[best])
            0: eLevel = 2'b10;
            1: eLevel = 2'b01;
            2: eLevel = 2'b00;
            default: eLevel = 2'b11;
          endcase
        end
      end
      if (doTake) mBusy = 10;
      else if (mBusy > 0) mBusy--;
      eBusy = mBusy != 0;
      mNmiPend = nmiHit && !doNmi;
      mNmiPrev = nmiReq;
      if (cfgWrEn && cfgWrIdx < NSRC) mPrio[cfgWrIdx] = rankOf(cfgWrLevel);
    end
  end

  task automatic checkOne(input string name, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn) begin
      checkOne("intTaken", int'(intTaken), int'(eTaken));
      checkOne("ccLoad",   int'(ccLoad),   int'(eLoad));
      checkOne("busy",     int'(busy),     int'(eBusy));
      checkOne("vecAddr",  int'(vecAddr),  int'(eVec));
      checkOne("ccLevel",  int'(ccLevel),  int'(eLevel));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    cyc(20000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    // R1: reset values, default level 11 observed through a take
    phase = "R1";
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    irqReq[3] = 1'b1; instrEnd = 1'b1;
    cyc(1);
    instrEnd = 1'b0; irqReq = '0;
    cyc(12);

    // R8: return with one entry, then with empty stack
    phase = "R8";
    retStrobe = 1'b1; cyc(1);
    retStrobe = 1'b0; cyc(1);
    retStrobe = 1'b1; cyc(1);
    retStrobe = 1'b0; cyc(1);

    // R9: level writes
    phase = "R9";
    cfgWrEn = 1'b1;
    cfgWrIdx = 4'd0;  cfgWrLevel = 2'b01; cyc(1);
    cfgWrIdx = 4'd5;  cfgWrLevel = 2'b00; cyc(1);
    cfgWrIdx = 4'd7;  cfgWrLevel = 2'b00; cyc(1);
    cfgWrIdx = 4'd9;  cfgWrLevel = 2'b01; cyc(1);
    cfgWrIdx = 4'd13; cfgWrLevel = 2'b10; cyc(1);
    cfgWrEn = 1'b0; cyc(1);

    // R2: strict-greater rule and full mask
    phase = "R2";
    curLevel = 2'b00; irqReq[9] = 1'b1; irqReq[5] = 1'b1; instrEnd = 1'b1; cyc(3);
    curLevel = 2'b11; irqReq[3] = 1'b1; cyc(3);
    curLevel = 2'b10; irqReq = '0; irqReq[13] = 1'b1; cyc(2);
    instrEnd = 1'b0; irqReq = '0; cyc(1);

    // R5: no boundary, no take
    phase = "R5";
    irqReq[0] = 1'b1; irqReq[5] = 1'b1; irqReq[7] = 1'b1; irqReq[9] = 1'b1;
    cyc(3);

    // R3: tie between 5 and 7 goes to 7
    phase = "R3";
    instrEnd = 1'b1; cyc(1);
    // R6: held request retaken right after busy window
    phase = "R6";
    cyc(14);
    instrEnd = 1'b0; irqReq = '0; cyc(1);

    // R3: higher rank beats higher index
    phase = "R3";
    curLevel = 2'b01;
    irqReq[0] = 1'b1; irqReq[9] = 1'b1; irqReq[3] = 1'b1; irqReq[5] = 1'b1;
    instrEnd = 1'b1; cyc(1);
    instrEnd = 1'b0; irqReq = '0; cyc(12);

    // R8: return suppresses a take, then pops until empty
    phase = "R8";
    curLevel = 2'b10; irqReq[3] = 1'b1; instrEnd = 1'b1; retStrobe = 1'b1; cyc(1);
    instrEnd = 1'b0; irqReq = '0; cyc(5);
    retStrobe = 1'b0; cyc(2);

    // R7: NMI at full mask, held level served once
    phase = "R7";
    curLevel = 2'b11; nmiReq = 1'b1; instrEnd = 1'b1; cyc(14);
    nmiReq = 1'b0; instrEnd = 1'b0; cyc(1);
    curLevel = 2'b10; irqReq[3] = 1'b1; nmiReq = 1'b1; cyc(1);
    nmiReq = 1'b0; cyc(1);
    instrEnd = 1'b1; cyc(14);
    instrEnd = 1'b0; irqReq = '0; cyc(1);
    retStrobe = 1'b1; cyc(2);
    retStrobe = 1'b0; cyc(1);

    // R10: overflow the stack, then drain it
    phase = "R10";
    for (int k = 0; k < 11; k++) begin
      curLevel = 2'(k);
      nmiReq = 1'b1; instrEnd = 1'b1; cyc(1);
      nmiReq = 1'b0; instrEnd = 1'b0; cyc(11);
    end
    retStrobe = 1'b1; cyc(10);
    retStrobe = 1'b0; cyc(3);

    finishRun();
  end

endmodule